// File: doc/BRIEF.md
# Host Parallel Byte Port

This block is a slave 8-bit parallel port through which an external host exchanges byte streams, such as MIDI traffic, with an internal controller. On the host side it has an active-low chip select, active-low read and write strobes, one register-select line, and an 8-bit data bus. The bus is split into input, output and output-enable so that a pad ring can form the bidirectional pin. The host strobes are asynchronous to the core clock. The block passes them through a two-flop synchroniser and commits each access when its strobe returns high.

On the core side the block presents two byte channels. A received byte from the host is offered with valid/ready. A byte for the host is accepted with valid/ready and announced to the host on an interrupt line. Host writes with the select line high go to a control byte that the controller reads directly. A status byte gives the host an inverted-sense handshake: one flag says whether a byte for the host is still pending, and one says whether the receive slot is occupied. A sticky flag records writes that were lost. The block also enforces a minimum spacing, counted in core clocks, between accepted host writes.

Top module: `host_byte_port`

## Requirements
- R1: After synchronous reset, `host_irq` is 0, `rx_valid` is 0, `tx_ready` is 1, `ctrl_byte` is 0x00, and the status byte reads 0x80.
- R2: `host_doe` is 1 only while `host_cs_n` and `host_rd_n` are both 0. During such a read, `host_sel`=1 returns the status byte and `host_sel`=0 returns the transmit byte. The status layout is: bit 7 send-empty (0 = byte pending for the host), bit 6 receive-full (0 = a new byte can be taken), bit 0 overrun, and bits 5..1 always 0.
- R3: A core-side push (`tx_valid` and `tx_ready` both 1 at a clock edge) stores the byte. It then clears status bit 7, raises `host_irq`, and holds `tx_ready` low until the host takes the byte.
- R4: A committed host data read (`host_sel`=0) sets status bit 7 and drops `host_irq`.
- R5: A committed host data write while status bit 6 is 0 stores the byte, sets bit 6, and raises `rx_valid`. `rx_valid` and `rx_data` then hold until `rx_ready` is sampled high, and that clears bit 6.
- R6: A committed host data write while status bit 6 is 1 discards the new byte, leaves the held byte unchanged, and sets the sticky overrun flag in status bit 0.
- R7: A committed host status read clears the overrun flag. The read that clears it still returns the flag as 1.
- R8: A committed host write with `host_sel`=1 loads `ctrl_byte`.
- R9: A host write committed fewer than WR_GAP (default 128) core clocks after the previous accepted write is ignored, for both data and control writes. Such a write sets no overrun.
- R10: If a host data write commits in the same cycle as the controller takes the held byte with `rx_ready`, the new byte is accepted and no overrun is flagged.
- R11: Read or write strobes given while `host_cs_n` is 1 have no effect.
- R12: An access is committed on the rising edge of its strobe, observed through the synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| host_cs_n | input | 1 | Host chip select, active low, asynchronous |
| host_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| host_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| host_sel | input | 1 | Register select: 0 data, 1 status (read) or control (write) |
| host_din | input | 8 | Data bus from host |
| host_dout | output | 8 | Data bus towards host |
| host_doe | output | 1 | Drive enable for the host data bus |
| host_irq | output | 1 | High while a byte waits for the host |
| rx_valid | output | 1 | Received host byte available |
| rx_data | output | 8 | Received host byte |
| rx_ready | input | 1 | Controller takes the received byte |
| tx_valid | input | 1 | Controller offers a byte for the host |
| tx_data | input | 8 | Byte for the host |
| tx_ready | output | 1 | Transmit slot is free |
| ctrl_byte | output | 8 | Last accepted control byte |

## Verification
The two functions that can land in one cycle are the host's data-write commit and the controller's pop of the received byte. Together they decide whether a byte is accepted or counted as overrun. The bench provokes this by releasing the write strobe and then placing a one-cycle `rx_ready` pulse exactly on the third core edge after release, which is where the synchroniser delivers the commit. It then judges the outcome by popping the second byte and reading status, which must show receive-full set and overrun clear. An additional checker property requires that such a coincidence never sets the overrun flag.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

  localparam int DW = 8;

  localparam int ST_SEND_EMPTY = 7;
  localparam int ST_RECV_FULL  = 6;
  localparam int ST_OVERRUN    = 0;

  typedef struct packed {
    logic          cs_n;
    logic          rd_n;
    logic          wr_n;
    logic          sel;
    logic [DW-1:0] d;
  } hbus_t;

  localparam int HBUS_W = $bits(hbus_t);

endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
  parameter int              W    = 12,
  parameter logic [W-1:0]    IDLE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] now_o,
  output logic [W-1:0] prev_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;
  logic [W-1:0] dly_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= IDLE;
      sync_q <= IDLE;
      dly_q  <= IDLE;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      dly_q  <= sync_q;
    end
  end

  assign now_o  = sync_q;
  assign prev_o = dly_q;

endmodule

// File: rtl/hbp_rx_slot.sv
module hbp_rx_slot #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          pop,
  input  logic          ovr_clr,
  output logic          full_o,
  output logic [DW-1:0] data_o,
  output logic          ovr_o
);

  logic          full_q;
  logic [DW-1:0] data_q;
  logic          ovr_q;
  logic          take;
  logic          accept;

  assign take   = pop & full_q;
  assign accept = wr_en & (~full_q | take);

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      data_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (accept) begin
        full_q <= 1'b1;
        data_q <= wr_data;
      end else if (take) begin
        full_q <= 1'b0;
      end
      if (wr_en && !accept) begin
        ovr_q <= 1'b1;
      end else if (ovr_clr) begin
        ovr_q <= 1'b0;
      end
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;
  assign ovr_o  = ovr_q;

endmodule

// File: rtl/hbp_tx_slot.sv
module hbp_tx_slot #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          take,
  output logic          full_o,
  output logic [DW-1:0] data_o
);

  logic          full_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (push && !full_q) begin
      full_q <= 1'b1;
      data_q <= push_data;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

endmodule

// File: rtl/hbp_wgap.sv
module hbp_wgap #(
  parameter int GAP = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic busy_o
);

  localparam int CW = $clog2(GAP + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (fire) begin
      cnt_q <= CW'(GAP - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/host_byte_port.sv
module host_byte_port
  import hbp_pkg::*;
#(
  parameter int WR_GAP = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_cs_n,
  input  logic          host_rd_n,
  input  logic          host_wr_n,
  input  logic          host_sel,
  input  logic [DW-1:0] host_din,
  output logic [DW-1:0] host_dout,
  output logic          host_doe,
  output logic          host_irq,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  input  logic          rx_ready,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  output logic          tx_ready,
  output logic [DW-1:0] ctrl_byte
);

  localparam logic [HBUS_W-1:0] BUS_IDLE = {1'b1, 1'b1, 1'b1, 1'b0, {DW{1'b0}}};

  hbus_t bus_raw;
  hbus_t now_q;
  hbus_t prev_q;

  assign bus_raw = '{cs_n: host_cs_n, rd_n: host_rd_n, wr_n: host_wr_n,
                     sel: host_sel, d: host_din};

  hbp_sync #(.W(HBUS_W), .IDLE(BUS_IDLE)) sync_i (
    .clk     (clk),
    .rst     (rst),
    .async_i (bus_raw),
    .now_o   (now_q),
    .prev_o  (prev_q)
  );

  logic unused_now;
  assign unused_now = ^{now_q.cs_n, now_q.sel, now_q.d};

  logic rd_commit;
  logic wr_commit;
  logic acc_sel;
  logic gap_busy;
  logic wr_ok;

  assign acc_sel   = prev_q.sel;
  assign rd_commit = now_q.rd_n & ~prev_q.rd_n & ~prev_q.cs_n;
  assign wr_commit = now_q.wr_n & ~prev_q.wr_n & ~prev_q.cs_n;
  assign wr_ok     = wr_commit & ~gap_busy;

  hbp_wgap #(.GAP(WR_GAP)) gap_i (
    .clk    (clk),
    .rst    (rst),
    .fire   (wr_ok),
    .busy_o (gap_busy)
  );

  logic          rx_full;
  logic          ovr;

  hbp_rx_slot #(.DW(DW)) rx_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_ok & ~acc_sel),
    .wr_data (prev_q.d),
    .pop     (rx_ready),
    .ovr_clr (rd_commit & acc_sel),
    .full_o  (rx_full),
    .data_o  (rx_data),
    .ovr_o   (ovr)
  );

  logic          tx_full;
  logic [DW-1:0] tx_hold;

  hbp_tx_slot #(.DW(DW)) tx_i (
    .clk       (clk),
    .rst       (rst),
    .push      (tx_valid),
    .push_data (tx_data),
    .take      (rd_commit & ~acc_sel),
    .full_o    (tx_full),
    .data_o    (tx_hold)
  );

  logic [DW-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_ok && acc_sel) begin
      ctrl_q <= prev_q.d;
    end
  end

  logic [DW-1:0] status;

  always_comb begin
    status                = '0;
    status[ST_SEND_EMPTY] = ~tx_full;
    status[ST_RECV_FULL]  = rx_full;
    status[ST_OVERRUN]    = ovr;
  end

  assign host_doe  = ~host_cs_n & ~host_rd_n;
  assign host_dout = host_sel ? status : tx_hold;
  assign host_irq  = tx_full;
  assign rx_valid  = rx_full;
  assign tx_ready  = ~tx_full;
  assign ctrl_byte = ctrl_q;

endmodule

// File: rtl/hbp_chk.sv
module hbp_chk (
  input logic       clk,
  input logic       rst,
  input logic       host_cs_n,
  input logic       host_doe,
  input logic       host_irq,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic [7:0] ctrl_byte,
  input logic       rd_commit,
  input logic       wr_commit,
  input logic       acc_sel,
  input logic       gap_busy,
  input logic       ovr
);

  // R2: bus never driven without chip select
  a_r2_bus_released: assert property (@(posedge clk) disable iff (rst)
    host_cs_n |-> !host_doe);

  // R3: a push announces the byte to the host
  a_r3_push_raises_irq: assert property (@(posedge clk) disable iff (rst)
    tx_valid && tx_ready |=> host_irq);

  // R4: a host data read retires the pending byte
  a_r4_read_drops_irq: assert property (@(posedge clk) disable iff (rst)
    rd_commit && !acc_sel && !(tx_valid && tx_ready) |=> !host_irq);

  // R5: held byte is stable until taken
  a_r5_rx_hold: assert property (@(posedge clk) disable iff (rst)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));

  // R6: write into an occupied slot is flagged
  a_r6_overrun_set: assert property (@(posedge clk) disable iff (rst)
    wr_commit && !gap_busy && !acc_sel && rx_valid && !rx_ready |=> ovr);

  // R9: write inside the spacing window leaves the control byte alone
  a_r9_gap_drop: assert property (@(posedge clk) disable iff (rst)
    wr_commit && gap_busy |=> $stable(ctrl_byte));

  // R10: same-cycle pop and write accepts the byte without overrun
  a_r10_pop_and_write: assert property (@(posedge clk) disable iff (rst)
    wr_commit && !gap_busy && !acc_sel && rx_valid && rx_ready && !ovr
    |=> rx_valid && !ovr);

endmodule

bind host_byte_port hbp_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .host_cs_n (host_cs_n),
  .host_doe  (host_doe),
  .host_irq  (host_irq),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .rx_data   (rx_data),
  .ctrl_byte (ctrl_byte),
  .rd_commit (rd_commit),
  .wr_commit (wr_commit),
  .acc_sel   (acc_sel),
  .gap_busy  (gap_busy),
  .ovr       (ovr)
);

// File: tb/host_byte_port_tb_top.sv
module host_byte_port_tb_top;

  localparam int GAP = 128;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_cs_n = 1'b1;
  logic       host_rd_n = 1'b1;
  logic       host_wr_n = 1'b1;
  logic       host_sel = 1'b0;
  logic [7:0] host_din = 8'h00;
  logic [7:0] host_dout;
  logic       host_doe;
  logic       host_irq;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       rx_ready = 1'b0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ready;
  logic [7:0] ctrl_byte;

  always #5 clk = ~clk;

  host_byte_port #(.WR_GAP(GAP)) dut_i (
    .clk(clk), .rst(rst),
    .host_cs_n(host_cs_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
    .host_sel(host_sel), .host_din(host_din),
    .host_dout(host_dout), .host_doe(host_doe), .host_irq(host_irq),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .ctrl_byte(ctrl_byte)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  task automatic chk(input int req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL R12 watchdog actual=running expected=done");
      finish_run();
    end
  end

  task automatic host_wr(input logic sel, input logic [7:0] d, input int gap);
    @(negedge clk); host_sel = sel; host_din = d; host_cs_n = 1'b0;
    @(negedge clk); host_wr_n = 1'b0;
    repeat (3) @(negedge clk);
    host_wr_n = 1'b1;
    repeat (3) @(negedge clk);
    host_cs_n = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  task automatic host_rd(input logic sel, output logic [7:0] d, output logic oe);
    @(negedge clk); host_sel = sel; host_cs_n = 1'b0;
    @(negedge clk); host_rd_n = 1'b0;
    repeat (3) @(negedge clk);
    d = host_dout; oe = host_doe;
    host_rd_n = 1'b1;
    repeat (4) @(negedge clk);
    host_cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk); tx_valid = 1'b1; tx_data = d;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic pop(input int req, input logic [7:0] exp);
    @(negedge clk);
    chk(req, {7'd0, rx_valid}, 8'h01);
    chk(req, rx_data, exp);
    rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  // vector: req[22:19] op[18:16] data[15:8] expect[7:0]
  // ops: 0 host data write, 1 host control write, 2 host data read,
  //      3 host status read, 4 core push, 5 core pop, 6 control check, 7 irq check
  localparam int NV = 21;
  localparam logic [22:0] VEC [NV] = '{
    {4'd3,  3'd4, 8'h3C, 8'h00},   // R3 push
    {4'd3,  3'd7, 8'h00, 8'h01},   // R3 irq high
    {4'd2,  3'd3, 8'h00, 8'h00},   // R2 status: pending, rx empty
    {4'd2,  3'd2, 8'h00, 8'h3C},   // R2 data read
    {4'd4,  3'd7, 8'h00, 8'h00},   // R4 irq low after read
    {4'd4,  3'd3, 8'h00, 8'h80},   // R4 send-empty set
    {4'd5,  3'd0, 8'h5A, 8'h00},   // R5 host write
    {4'd5,  3'd3, 8'h00, 8'hC0},   // R5 receive-full
    {4'd6,  3'd0, 8'h11, 8'h00},   // R6 write while full
    {4'd6,  3'd3, 8'h00, 8'hC1},   // R6 overrun seen
    {4'd7,  3'd3, 8'h00, 8'hC0},   // R7 cleared by previous status read
    {4'd6,  3'd5, 8'h00, 8'h5A},   // R6 held byte unchanged
    {4'd5,  3'd3, 8'h00, 8'h80},   // R5 slot freed
    {4'd8,  3'd1, 8'hA7, 8'h00},   // R8 control write
    {4'd8,  3'd6, 8'h00, 8'hA7},   // R8 control value
    {4'd3,  3'd4, 8'hE1, 8'h00},   // R3 push second pattern
    {4'd2,  3'd2, 8'h00, 8'hE1},   // R2 data read
    {4'd8,  3'd1, 8'h0F, 8'h00},   // R8 control write
    {4'd8,  3'd6, 8'h00, 8'h0F},   // R8 control value
    {4'd5,  3'd0, 8'h00, 8'h00},   // R5 write zero byte
    {4'd5,  3'd5, 8'h00, 8'h00}    // R5 pop zero byte
  };

  initial begin
    logic [7:0] rd_v;
    logic       oe_v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk(1, {7'd0, host_irq}, 8'h00);
    chk(1, {7'd0, rx_valid}, 8'h00);
    chk(1, {7'd0, tx_ready}, 8'h01);
    chk(1, ctrl_byte, 8'h00);
    host_rd(1'b1, rd_v, oe_v);
    chk(1, rd_v, 8'h80);
    chk(2, {7'd0, oe_v}, 8'h01);

    // R2 drive enable only with both low; R11 read strobe without select
    @(negedge clk); host_cs_n = 1'b0;
    @(negedge clk); chk(2, {7'd0, host_doe}, 8'h00);
    host_cs_n = 1'b1; host_rd_n = 1'b0;
    @(negedge clk); chk(11, {7'd0, host_doe}, 8'h00);
    host_rd_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      int         req;
      logic [2:0] op;
      logic [7:0] dv;
      logic [7:0] ev;
      req = int'(VEC[i][22:19]);
      op  = VEC[i][18:16];
      dv  = VEC[i][15:8];
      ev  = VEC[i][7:0];
      case (op)
        3'd0: host_wr(1'b0, dv, GAP + 12);
        3'd1: host_wr(1'b1, dv, GAP + 12);
        3'd2: begin host_rd(1'b0, rd_v, oe_v); chk(req, rd_v, ev); end
        3'd3: begin host_rd(1'b1, rd_v, oe_v); chk(req, rd_v, ev); end
        3'd4: push(dv);
        3'd5: pop(req, ev);
        3'd6: begin @(negedge clk); chk(req, ctrl_byte, ev); end
        default: begin @(negedge clk); chk(req, {7'd0, host_irq}, ev); end
      endcase
    end

    // R11: strobes with chip select high
    push(8'h42);
    @(negedge clk); host_sel = 1'b0; host_rd_n = 1'b0;
    repeat (3) @(negedge clk); host_rd_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(11, {7'd0, host_irq}, 8'h01);
    host_din = 8'h77; host_wr_n = 1'b0;
    repeat (3) @(negedge clk); host_wr_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(11, {7'd0, rx_valid}, 8'h00);
    host_rd(1'b0, rd_v, oe_v);
    chk(11, rd_v, 8'h42);

    // R12: nothing committed while strobe is still low
    @(negedge clk); host_sel = 1'b1; host_din = 8'h3E; host_cs_n = 1'b0;
    @(negedge clk); host_wr_n = 1'b0;
    repeat (8) @(negedge clk);
    chk(12, ctrl_byte, 8'h0F);
    host_wr_n = 1'b1;
    repeat (3) @(negedge clk);
    host_cs_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(12, ctrl_byte, 8'h3E);
    repeat (GAP + 10) @(negedge clk);

    // R9: write too soon after previous one is dropped
    host_wr(1'b1, 8'h55, 20);
    host_wr(1'b1, 8'h66, GAP + 12);
    chk(9, ctrl_byte, 8'h55);
    host_wr(1'b0, 8'h90, 20);
    host_wr(1'b0, 8'h91, GAP + 12);
    host_rd(1'b1, rd_v, oe_v);
    chk(9, rd_v, 8'hC0);
    pop(9, 8'h90);
    host_wr(1'b1, 8'h66, GAP + 12);
    chk(9, ctrl_byte, 8'h66);

    // R10: host write commit coincides with core pop
    host_wr(1'b0, 8'h21, GAP + 12);
    @(negedge clk); chk(10, rx_data, 8'h21);
    host_sel = 1'b0; host_din = 8'h34; host_cs_n = 1'b0;
    @(negedge clk); host_wr_n = 1'b0;
    repeat (3) @(negedge clk);
    host_wr_n = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
    repeat (2) @(negedge clk);
    host_cs_n = 1'b1;
    repeat (GAP + 10) @(negedge clk);
    host_rd(1'b1, rd_v, oe_v);
    chk(10, rd_v, 8'hC0);
    pop(10, 8'h34);

    finish_run();
  end

endmodule